// File: doc/BRIEF.md
# Precise Exception Pipeline Tracker

This block follows every instruction through a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. It keeps a small fault record with each instruction. Any stage may flag a fault for the instruction it currently holds. The flag is written into that instruction's record and travels with it, and no action is taken while the instruction is in flight. The record is examined only at writeback. A clean instruction retires there. A faulted instruction retires nothing. In that same cycle every younger instruction becomes a bubble, the exception PC, the cause and a delay-slot flag are latched, and fetch moves to a fixed handler address on the next cycle.

Because the decision waits for writeback, exceptions always come out in program order. An older instruction's memory fault wins over a younger instruction's fetch fault, even when the younger fault is raised at an earlier time. If an instruction in a branch delay slot faults, the block reports the branch's PC and sets the delay-slot flag. The fault inputs are plain per-stage signals; there is no address translation here. The fetch controller is a three-state machine:
- FS_BOOT is the single cycle after reset, with no fetch. It always goes to FS_RUN.
- FS_RUN fetches sequentially. It stays in FS_RUN, and moves to FS_REDIRECT on a taken exception.
- FS_REDIRECT fetches from the handler address. It always returns to FS_RUN.

Top module: `exc_precise_pipe`

## Requirements
- R1: After reset `fetch_pc_o` equals RESET_PC (0), and `wb_valid_o`, `exc_taken_o`, `epc_o`, `cause_o` and `bd_o` are all zero. The first cycle after reset fetches nothing, so RESET_PC is shown for two cycles.
- R2: While no exception is taken, `fetch_pc_o` advances by STEP (4) each cycle. A fault-free instruction fetched in cycle c retires in cycle c+4, with `wb_valid_o`=1 and `wb_pc_o` equal to its PC.
- R3: Cause codes on `cause_o` are as follows. Fetch fault input 1, 2 or 3 (page fault, misaligned, protection) gives 1, 2 or 3. An illegal opcode in decode gives 4. An arithmetic fault in execute gives 5. Memory fault input 1, 2 or 3 (page fault, misaligned, protection) gives 6, 7 or 8. A fault input of 0 means no fault.
- R4: A recorded fault has no visible effect until its instruction reaches writeback. There, `exc_taken_o`=1 and `wb_valid_o`=0 in the same cycle.
- R5: When one instruction collects several faults, the fault from the earliest stage is the one reported.
- R6: Exceptions are taken in program order. An older instruction's fault is reported even when a younger instruction faulted earlier in time, and the younger fault is never reported.
- R7: On a taken exception, all four younger instructions become bubbles. For the next four cycles `wb_valid_o`=0 and `exc_taken_o`=0.
- R8: `epc_o`, `cause_o` and `bd_o` load at the clock edge that ends the exception cycle and hold their values at all other times.
- R9: A faulting instruction in a branch delay slot (fetched while `dec_branch_i` marked a valid instruction in decode) reports the branch's PC (its own PC minus STEP) on `epc_o` and sets `bd_o`=1. Otherwise `bd_o`=0 and `epc_o` is the instruction's own PC.
- R10: In the cycle after an exception, `fetch_pc_o` equals VECTOR_PC (0x80). Fetch then continues sequentially from there, and the handler's first instruction retires four cycles later.
- R11: A fault input for a stage that holds a bubble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_fault_i | input | 2 | Fetch-stage fault: 0 none, 1 page fault, 2 misaligned, 3 protection |
| dec_branch_i | input | 1 | Instruction in decode is a branch; the instruction in fetch is its delay slot |
| dec_illegal_i | input | 1 | Instruction in decode has an illegal opcode |
| exe_arith_i | input | 1 | Instruction in execute raised an arithmetic fault |
| mem_fault_i | input | 2 | Memory-stage fault: 0 none, 1 page fault, 2 misaligned, 3 protection |
| fetch_pc_o | output | AW | PC fetched this cycle |
| wb_valid_o | output | 1 | Writeback instruction retires and updates state |
| wb_pc_o | output | AW | PC of the retiring instruction |
| exc_taken_o | output | 1 | Writeback instruction faulted; younger instructions are flushed |
| epc_o | output | AW | Latched exception PC |
| cause_o | output | 4 | Latched cause code |
| bd_o | output | 1 | Latched delay-slot flag |

## Verification
A stale cause in one of the in-flight records shows up at `cause_o` exactly when that instruction reaches writeback, and no earlier. So an error can stay hidden for up to four cycles and then appear as a wrong code or a missing retirement. A flush that misses a stage appears as a `wb_valid_o` or `exc_taken_o` inside the four-cycle shadow after an exception. A wrong fetch state appears one cycle after the exception as a `fetch_pc_o` other than the handler address. The bench runs a cycle-accurate model of all five stage records. It compares every output on every cycle across a long stream of mixed faults and branches, so a divergence is caught in the cycle it first reaches a port.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [3:0] {
        CAUSE_NONE  = 4'd0,
        CAUSE_IPF   = 4'd1,
        CAUSE_IMIS  = 4'd2,
        CAUSE_IPROT = 4'd3,
        CAUSE_ILL   = 4'd4,
        CAUSE_ARITH = 4'd5,
        CAUSE_DPF   = 4'd6,
        CAUSE_DMIS  = 4'd7,
        CAUSE_DPROT = 4'd8
    } cause_e;

    typedef enum logic [1:0] {
        FS_BOOT     = 2'd0,
        FS_RUN      = 2'd1,
        FS_REDIRECT = 2'd2
    } fetch_state_e;

endpackage

// File: rtl/exc_fetch_fsm.sv
module exc_fetch_fsm
    import exc_pkg::*;
#(
    parameter int          AW        = 32,
    parameter logic [AW-1:0] RESET_PC  = '0,
    parameter logic [AW-1:0] VECTOR_PC = 'h80,
    parameter int          STEP      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          exc_i,
    output logic [AW-1:0] fetch_pc_o,
    output logic          fetch_valid_o,
    output fetch_state_e  state_o
);

    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    fetch_state_e  state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_BOOT;
            pc_q    <= RESET_PC;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // next state and sequential PC
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            FS_BOOT: begin
                state_d = FS_RUN;
            end
            FS_RUN: begin
                pc_d    = pc_q + STEP_W;
                state_d = exc_i ? FS_REDIRECT : FS_RUN;
            end
            FS_REDIRECT: begin
                pc_d    = VECTOR_PC + STEP_W;
                state_d = FS_RUN;
            end
            default: begin
                state_d = FS_BOOT;
            end
        endcase
    end

    // outputs
    always_comb begin
        fetch_pc_o    = pc_q;
        fetch_valid_o = 1'b0;
        unique case (state_q)
            FS_BOOT: begin
                fetch_valid_o = 1'b0;
            end
            FS_RUN: begin
                fetch_valid_o = 1'b1;
            end
            FS_REDIRECT: begin
                fetch_pc_o    = VECTOR_PC;
                fetch_valid_o = 1'b1;
            end
            default: begin
                fetch_valid_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/exc_stage.sv
module exc_stage
    import exc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          in_valid_i,
    input  logic [AW-1:0] in_pc_i,
    input  logic          in_bd_i,
    input  cause_e        in_cause_i,
    input  cause_e        code_i,
    output logic          out_valid_o,
    output logic [AW-1:0] out_pc_o,
    output logic          out_bd_o,
    output cause_e        out_cause_o
);

    // an already recorded (earlier-stage) cause is never overwritten
    cause_e merged;
    always_comb begin
        if (!in_valid_i)
            merged = CAUSE_NONE;
        else if (in_cause_i != CAUSE_NONE)
            merged = in_cause_i;
        else
            merged = code_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            out_pc_o    <= '0;
            out_bd_o    <= 1'b0;
            out_cause_o <= CAUSE_NONE;
        end else if (flush_i) begin
            out_valid_o <= 1'b0;
            out_bd_o    <= 1'b0;
            out_cause_o <= CAUSE_NONE;
        end else begin
            out_valid_o <= in_valid_i;
            out_pc_o    <= in_pc_i;
            out_bd_o    <= in_valid_i & in_bd_i;
            out_cause_o <= merged;
        end
    end

endmodule

// File: rtl/exc_commit.sv
module exc_commit
    import exc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          w_valid_i,
    input  logic [AW-1:0] w_pc_i,
    input  logic          w_bd_i,
    input  cause_e        w_cause_i,
    output logic          wb_valid_o,
    output logic [AW-1:0] wb_pc_o,
    output logic          exc_o,
    output logic [AW-1:0] epc_o,
    output logic [3:0]    cause_o,
    output logic          bd_o
);

    localparam logic [AW-1:0] STEP_W = AW'(STEP);

    logic          faulted;
    logic [AW-1:0] epc_next;

    assign faulted    = w_valid_i && (w_cause_i != CAUSE_NONE);
    assign exc_o      = faulted;
    assign wb_valid_o = w_valid_i && (w_cause_i == CAUSE_NONE);
    assign wb_pc_o    = w_pc_i;
    // a delay-slot instruction always directly follows its branch
    assign epc_next   = w_bd_i ? (w_pc_i - STEP_W) : w_pc_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_o   <= '0;
            cause_o <= 4'd0;
            bd_o    <= 1'b0;
        end else if (faulted) begin
            epc_o   <= epc_next;
            cause_o <= w_cause_i;
            bd_o    <= w_bd_i;
        end
    end

endmodule

// File: rtl/exc_precise_pipe.sv
module exc_precise_pipe
    import exc_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] RESET_PC  = '0,
    parameter logic [AW-1:0] VECTOR_PC = 'h80,
    parameter int            STEP      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fetch_fault_i,
    input  logic          dec_branch_i,
    input  logic          dec_illegal_i,
    input  logic          exe_arith_i,
    input  logic [1:0]    mem_fault_i,
    output logic [AW-1:0] fetch_pc_o,
    output logic          wb_valid_o,
    output logic [AW-1:0] wb_pc_o,
    output logic          exc_taken_o,
    output logic [AW-1:0] epc_o,
    output logic [3:0]    cause_o,
    output logic          bd_o
);

    localparam int NSTAGE = 5;
    localparam int NREG   = NSTAGE - 1;

    // index 0 is the fetch stage (combinational), 1..NREG are registered
    logic          st_valid [NSTAGE];
    logic [AW-1:0] st_pc    [NSTAGE];
    logic          st_bd    [NSTAGE];
    cause_e        st_cause [NSTAGE];
    cause_e        st_code  [NREG];

    logic          fetch_valid;
    logic          flush;
    fetch_state_e  fsm_state;

    exc_fetch_fsm #(
        .AW        (AW),
        .RESET_PC  (RESET_PC),
        .VECTOR_PC (VECTOR_PC),
        .STEP      (STEP)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .exc_i         (flush),
        .fetch_pc_o    (fetch_pc_o),
        .fetch_valid_o (fetch_valid),
        .state_o       (fsm_state)
    );

    // per-stage fault encoding
    assign st_code[0] = cause_e'({2'b00, fetch_fault_i});
    assign st_code[1] = dec_illegal_i ? CAUSE_ILL : CAUSE_NONE;
    assign st_code[2] = exe_arith_i ? CAUSE_ARITH : CAUSE_NONE;
    assign st_code[3] = (mem_fault_i == 2'b00) ? CAUSE_NONE
                      : cause_e'(4'd5 + {2'b00, mem_fault_i});

    assign st_valid[0] = fetch_valid;
    assign st_pc[0]    = fetch_pc_o;
    assign st_bd[0]    = dec_branch_i & st_valid[1];
    assign st_cause[0] = CAUSE_NONE;

    for (genvar g = 1; g < NSTAGE; g++) begin : g_stage
        exc_stage #(.AW(AW)) u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .flush_i     (flush),
            .in_valid_i  (st_valid[g-1]),
            .in_pc_i     (st_pc[g-1]),
            .in_bd_i     (st_bd[g-1]),
            .in_cause_i  (st_cause[g-1]),
            .code_i      (st_code[g-1]),
            .out_valid_o (st_valid[g]),
            .out_pc_o    (st_pc[g]),
            .out_bd_o    (st_bd[g]),
            .out_cause_o (st_cause[g])
        );
    end

    exc_commit #(.AW(AW), .STEP(STEP)) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .w_valid_i  (st_valid[NREG]),
        .w_pc_i     (st_pc[NREG]),
        .w_bd_i     (st_bd[NREG]),
        .w_cause_i  (st_cause[NREG]),
        .wb_valid_o (wb_valid_o),
        .wb_pc_o    (wb_pc_o),
        .exc_o      (flush),
        .epc_o      (epc_o),
        .cause_o    (cause_o),
        .bd_o       (bd_o)
    );

    assign exc_taken_o = flush;

endmodule

// File: rtl/exc_precise_pipe_chk.sv
module exc_precise_pipe_chk
    import exc_pkg::*;
#(
    parameter int            AW        = 32,
    parameter logic [AW-1:0] VECTOR_PC = 'h80,
    parameter int            STEP      = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exc_taken,
    input logic          wb_valid,
    input logic [AW-1:0] fetch_pc,
    input logic [AW-1:0] epc,
    input logic [3:0]    cause,
    input logic          bd,
    input fetch_state_e  fsm_state
);

    // R4
    no_commit_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_taken && wb_valid));

    // R7
    flush_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (!exc_taken && !wb_valid));

    // R10
    vector_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (fetch_pc == VECTOR_PC));

    // R8
    record_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_taken |=> ($stable(cause) && $stable(epc) && $stable(bd)));

    // R3
    cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> (cause != 4'd0 && cause <= 4'd8));

    // R2
    seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == FS_RUN && !exc_taken) |=> (fetch_pc == $past(fetch_pc) + AW'(STEP)));

endmodule

bind exc_precise_pipe exc_precise_pipe_chk #(
    .AW        (AW),
    .VECTOR_PC (VECTOR_PC),
    .STEP      (STEP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_taken (exc_taken_o),
    .wb_valid  (wb_valid_o),
    .fetch_pc  (fetch_pc_o),
    .epc       (epc_o),
    .cause     (cause_o),
    .bd        (bd_o),
    .fsm_state (fsm_state)
);

// File: tb/exc_precise_pipe_tb.sv
module exc_precise_pipe_tb;

    localparam int          AW   = 32;
    localparam logic [31:0] RSTV = 32'h0;
    localparam logic [31:0] VEC  = 32'h80;
    localparam logic [31:0] STEP = 32'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fetch_fault_i = 2'b0;
    logic        dec_branch_i = 1'b0;
    logic        dec_illegal_i = 1'b0;
    logic        exe_arith_i = 1'b0;
    logic [1:0]  mem_fault_i = 2'b0;
    logic [31:0] fetch_pc_o, wb_pc_o, epc_o;
    logic        wb_valid_o, exc_taken_o, bd_o;
    logic [3:0]  cause_o;

    exc_precise_pipe #(.AW(AW), .RESET_PC(RSTV), .VECTOR_PC(VEC), .STEP(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_fault_i(fetch_fault_i), .dec_branch_i(dec_branch_i),
        .dec_illegal_i(dec_illegal_i), .exe_arith_i(exe_arith_i), .mem_fault_i(mem_fault_i),
        .fetch_pc_o(fetch_pc_o), .wb_valid_o(wb_valid_o), .wb_pc_o(wb_pc_o),
        .exc_taken_o(exc_taken_o), .epc_o(epc_o), .cause_o(cause_o), .bd_o(bd_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model: 0 boot, 1 run, 2 redirect
    int          ms;
    logic [31:0] mpcq;
    logic        mv  [1:4];
    logic [31:0] mpc [1:4];
    logic        mbd [1:4];
    logic [3:0]  mc  [1:4];
    logic [31:0] mepc;
    logic [3:0]  mcr;
    logic        mbdr;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        ms = 0; mpcq = RSTV; mepc = '0; mcr = '0; mbdr = 1'b0;
        for (int j = 1; j <= 4; j++) begin
            mv[j] = 1'b0; mpc[j] = '0; mbd[j] = 1'b0; mc[j] = '0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fetch_fault_i = 0; dec_branch_i = 0; dec_illegal_i = 0; exe_arith_i = 0; mem_fault_i = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        chk("R1 fetch_pc", fetch_pc_o, RSTV);
        chk("R1 wb_valid", {31'b0, wb_valid_o}, 32'd0);
        chk("R1 exc_taken", {31'b0, exc_taken_o}, 32'd0);
        chk("R1 epc", epc_o, 32'd0);
        chk("R1 cause", {28'b0, cause_o}, 32'd0);
        chk("R1 bd", {31'b0, bd_o}, 32'd0);
    endtask

    task automatic step(input logic [1:0] ff, input logic il, input logic ar,
                        input logic [1:0] mf, input logic br);
        logic [31:0] fpc;
        logic        fv, e_exc, e_wb;
        logic [3:0]  code [1:4];
        logic        nv  [1:4];
        logic [31:0] npc [1:4];
        logic        nbd [1:4];
        logic [3:0]  nc  [1:4];
        fetch_fault_i = ff; dec_illegal_i = il; exe_arith_i = ar; mem_fault_i = mf; dec_branch_i = br;
        #1;
        fpc   = (ms == 2) ? VEC : mpcq;
        fv    = (ms != 0);
        e_exc = mv[4] && (mc[4] != 0);
        e_wb  = mv[4] && (mc[4] == 0);
        chk((ms == 2) ? "R10 fetch_pc" : "R2 fetch_pc", fetch_pc_o, fpc);
        chk("R4 exc_taken", {31'b0, exc_taken_o}, {31'b0, e_exc});
        chk("R2 wb_valid", {31'b0, wb_valid_o}, {31'b0, e_wb});
        if (e_wb) chk("R2 wb_pc", wb_pc_o, mpc[4]);
        chk("R8 epc", epc_o, mepc);
        chk("R8 cause", {28'b0, cause_o}, {28'b0, mcr});
        chk("R8 bd", {31'b0, bd_o}, {31'b0, mbdr});
        // R3 cause encoding
        code[1] = {2'b00, ff};
        code[2] = il ? 4'd4 : 4'd0;
        code[3] = ar ? 4'd5 : 4'd0;
        code[4] = (mf == 0) ? 4'd0 : 4'd5 + {2'b00, mf};
        nv[1]  = !e_exc && fv;
        npc[1] = fpc;
        nbd[1] = nv[1] && br && mv[1];
        nc[1]  = nv[1] ? code[1] : 4'd0;
        for (int j = 2; j <= 4; j++) begin
            nv[j]  = !e_exc && mv[j-1];
            npc[j] = mpc[j-1];
            nbd[j] = nv[j] && mbd[j-1];
            nc[j]  = nv[j] ? ((mc[j-1] != 0) ? mc[j-1] : code[j]) : 4'd0;
        end
        @(posedge clk);
        if (e_exc) begin
            mepc = mbd[4] ? (mpc[4] - STEP) : mpc[4];
            mcr  = mc[4];
            mbdr = mbd[4];
        end
        if (ms != 0) mpcq = fpc + STEP;
        ms = (ms == 1 && e_exc) ? 2 : 1;
        for (int j = 1; j <= 4; j++) begin
            mv[j] = nv[j]; mpc[j] = npc[j]; mbd[j] = nbd[j]; mc[j] = nc[j];
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(2'd0, 1'b0, 1'b0, 2'd0, 1'b0);
    endtask

    function automatic logic [31:0] next_lfsr(input logic [31:0] v);
        return {v[30:0], 1'b0} ^ (v[31] ? 32'h0400_0007 : 32'h0);
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        // Scenario A: older memory fault against younger fetch fault (R6), flush (R7), redirect (R10), bubbles (R11)
        do_reset();
        idle(4);
        step(2'd1, 1'b0, 1'b0, 2'd1, 1'b0);   // cycle 4: M holds pc 0, F holds pc 12
        idle(1);                              // cycle 5: exception at writeback
        #1;
        chk("R6 cause", {28'b0, cause_o}, 32'd6);
        chk("R6 epc", epc_o, 32'd0);
        chk("R10 vector", fetch_pc_o, VEC);
        chk("R7 wb_valid", {31'b0, wb_valid_o}, 32'd0);
        step(2'd0, 1'b1, 1'b1, 2'd3, 1'b0);   // cycle 6: faults on bubble stages
        for (int k = 7; k <= 9; k++) begin
            #1;
            chk("R7 wb_valid", {31'b0, wb_valid_o}, 32'd0);
            chk("R11 exc_taken", {31'b0, exc_taken_o}, 32'd0);
            idle(1);
        end
        #1;
        chk("R10 handler retires", {31'b0, wb_valid_o}, 32'd1);
        chk("R10 handler pc", wb_pc_o, VEC);
        chk("R11 no exception", {31'b0, exc_taken_o}, 32'd0);

        // Scenario B: delay slot (R9) with several faults on one instruction (R5)
        do_reset();
        idle(2);
        step(2'd2, 1'b0, 1'b0, 2'd0, 1'b1);   // cycle 2: pc 0 branch in D, pc 4 misaligned fetch
        step(2'd0, 1'b1, 1'b0, 2'd0, 1'b0);   // cycle 3: pc 4 illegal in D
        idle(1);
        #1;
        chk("R2 retire pc0 valid", {31'b0, wb_valid_o}, 32'd1);
        chk("R2 retire pc0", wb_pc_o, 32'd0);
        step(2'd0, 1'b0, 1'b0, 2'd1, 1'b0);   // cycle 5: pc 4 data fault in M
        #1;
        chk("R4 exc at writeback", {31'b0, exc_taken_o}, 32'd1);
        idle(1);
        #1;
        chk("R5 earliest cause", {28'b0, cause_o}, 32'd2);
        chk("R9 epc branch", epc_o, 32'd0);
        chk("R9 bd", {31'b0, bd_o}, 32'd1);

        // Scenario C: arithmetic fault deferred to writeback (R4, R3)
        do_reset();
        idle(5);
        step(2'd0, 1'b0, 1'b1, 2'd0, 1'b0);   // cycle 5: pc 8 in X
        #1;
        chk("R4 deferred", {31'b0, exc_taken_o}, 32'd0);
        idle(2);
        #1;
        chk("R3 arith cause", {28'b0, cause_o}, 32'd5);
        chk("R8 epc", epc_o, 32'd8);
        chk("R8 bd clear", {31'b0, bd_o}, 32'd0);

        // Sweep: long mixed stream against the model (R2 R3 R5 R6 R7 R8 R9 R10 R11)
        do_reset();
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] ff, mf;
            logic il, ar, br;
            lfsr = next_lfsr(lfsr); lfsr = next_lfsr(lfsr); lfsr = next_lfsr(lfsr);
            ff = (lfsr[3:0] == 0) ? lfsr[5:4] : 2'd0;
            il = (lfsr[9:6] == 0);
            ar = (lfsr[13:10] == 0);
            mf = (lfsr[17:14] == 0) ? lfsr[19:18] : 2'd0;
            br = (lfsr[21:20] == 0);
            step(ff, il, ar, mf, br);
        end
        summary();
    end

endmodule